// File: doc/BRIEF.md
# Channel Interrupt Status Unit

This block gathers the interrupt sources of one transfer channel into a status register. Software reads it through a small register bus, masks it with a separate enable register, and acknowledges sources by writing ones to a clear register. The channel's event pulses set status bits. A level input tells the block that event records are still waiting in the event ring. While that input is high the completion bit cannot be acknowledged away, so the interrupt keeps asking for service until software has drained the ring.

The sources fall into two groups: a normal completion source and a group of error sources. Any enabled error source raises a halt indication. The channel controller uses it to suspend the channel. A control register picks how the interrupt is delivered. One setting drives a level interrupt line. The other produces a single-cycle message request pulse for every cycle in which a new enabled cause appears. The message transport itself and the bus fabric sit outside this block.

Top module: `chan_irq_unit`

## Requirements
- R1: Register offsets on the byte-addressed bus are fixed: status at 0x100 (read-only), clear at 0x108 (write-only, reads as zero), enable at 0x110 (read/write), and delivery control at 0x004 (low 4 bits read/write, upper bits read as zero). A read of any other offset returns zero. Read data is combinational and valid while `rd_en` is high.
- R2: The only implemented source bits are 0 (completion), 1 (event write-response error), 9 (descriptor read-response error), 10 (data read error), 11 (data write error) and 14 (invalid descriptor error). This is mask 0x4E03. A one-cycle pulse on an implemented bit of `src_evt` sets that status bit at the next clock edge. Other bits never set, and the enable register stores only implemented bits.
- R3: Writing 1 to a bit of the clear register clears that status bit at the next edge, and writing 0 leaves it unchanged. A source pulse in the same cycle as a clear of the same bit leaves the bit set.
- R4: While `evt_pending` is high, status bit 0 is set at every edge, so a clear of bit 0 has no effect. After `evt_pending` falls, a clear of bit 0 takes effect.
- R5: Status records a source whether or not it is enabled. The cause is status AND enable.
- R6: When the control nibble equals 1 (wired mode), `irq_line` is the OR of all cause bits. With any other nibble value, `irq_line` is 0.
- R7: In message mode, `msg_req` is high for exactly one cycle: the cycle after an edge at which at least one cause bit went from 0 to 1. A cause bit that is already set gives no further pulse. In wired mode `msg_req` stays 0.
- R8: `err_halt` is high whenever any cause bit in the error set {1, 9, 10, 11, 14} is set. The completion bit 0 alone never raises it.
- R9: After reset, status is 0, enable is 0, the control nibble is 1 (wired), and `irq_line`, `msg_req` and `err_halt` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_evt | input | 16 | One-cycle source event pulses, one per status bit |
| evt_pending | input | 1 | High while unconsumed event records remain |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 12 | Byte offset of the register access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, zero when not reading |
| irq_line | output | 1 | Level interrupt, wired mode only |
| msg_req | output | 1 | One-cycle message request, message mode only |
| err_halt | output | 1 | An enabled error source is set |

## Verification
The bench drives a source pulse and a clear of the same bit in one cycle. A design that gave the clear priority would lose that event and read the bit back as zero. It tries to acknowledge the completion bit while `evt_pending` is high. A design that treated the pending level as an ordinary pulse would drop the interrupt while records remain. It pulses a bit that is already set while in message mode and expects no second request, which catches a design that pulses on every event instead of on a new cause. It also checks that completion alone leaves `err_halt` low and that a disabled error source is recorded but raises nothing.

// File: rtl/isu_pkg.sv
package isu_pkg;

  localparam int unsigned OFS_CTRL = 32'h004;
  localparam int unsigned OFS_STAT = 32'h100;
  localparam int unsigned OFS_CLR  = 32'h108;
  localparam int unsigned OFS_EN   = 32'h110;

  localparam int unsigned BIT_DONE     = 0;
  localparam int unsigned BIT_EVWR_ERR = 1;
  localparam int unsigned BIT_DRD_ERR  = 9;
  localparam int unsigned BIT_RD_ERR   = 10;
  localparam int unsigned BIT_WR_ERR   = 11;
  localparam int unsigned BIT_BAD_DESC = 14;

  localparam int unsigned MODE_WIRED = 1;

  // true for every source that signals a failure
  function automatic bit is_err_src(input int unsigned b);
    return (b == BIT_EVWR_ERR) || (b == BIT_DRD_ERR) || (b == BIT_RD_ERR) ||
           (b == BIT_WR_ERR)   || (b == BIT_BAD_DESC);
  endfunction

  // true for every source that has a status flop
  function automatic bit is_impl_src(input int unsigned b);
    return (b == BIT_DONE) || is_err_src(b);
  endfunction

  // mask of width 32 with one bit per selected source
  function automatic logic [31:0] src_mask(input bit only_err);
    logic [31:0] m;
    m = '0;
    for (int unsigned i = 0; i < 32; i++) begin
      m[i] = only_err ? is_err_src(i) : is_impl_src(i);
    end
    return m;
  endfunction

  // cause bits that were clear last cycle and are set now
  function automatic logic [31:0] new_bits(input logic [31:0] now_v,
                                           input logic [31:0] prev_v);
    return now_v & ~prev_v;
  endfunction

endpackage

// File: rtl/isu_status.sv
module isu_status
  import isu_pkg::*;
#(
  parameter int SRC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SRC_W-1:0] set_vec,
  input  logic [SRC_W-1:0] clr_vec,
  output logic [SRC_W-1:0] stat_q
);

  localparam logic [SRC_W-1:0] IMPL = SRC_W'(src_mask(1'b0));

  logic [SRC_W-1:0] unused_tie;
  assign unused_tie = (set_vec | clr_vec) & ~IMPL;

  for (genvar b = 0; b < SRC_W; b++) begin : g_bit
    if (is_impl_src(b)) begin : g_flop
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          stat_q[b] <= 1'b0;
        end else if (set_vec[b]) begin
          stat_q[b] <= 1'b1;
        end else if (clr_vec[b]) begin
          stat_q[b] <= 1'b0;
        end
      end
    end else begin : g_tie
      assign stat_q[b] = 1'b0;
    end
  end

endmodule

// File: rtl/isu_regs.sv
module isu_regs
  import isu_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int SRC_W  = 16,
  parameter int MODE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [SRC_W-1:0]  stat_q,
  output logic [SRC_W-1:0]  en_q,
  output logic [MODE_W-1:0] mode_q,
  output logic [SRC_W-1:0]  clr_vec,
  output logic [DATA_W-1:0] rdata
);

  localparam logic [SRC_W-1:0]  IMPL = SRC_W'(src_mask(1'b0));
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);
  localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(OFS_CLR);
  localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(OFS_EN);

  logic hit_ctrl, hit_stat, hit_clr, hit_en;
  assign hit_ctrl = (addr == A_CTRL);
  assign hit_stat = (addr == A_STAT);
  assign hit_clr  = (addr == A_CLR);
  assign hit_en   = (addr == A_EN);

  logic unused_hi;
  assign unused_hi = ^wdata[DATA_W-1:SRC_W];

  assign clr_vec = (wr_en && hit_clr) ? (wdata[SRC_W-1:0] & IMPL) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      mode_q <= MODE_W'(MODE_WIRED);
    end else if (wr_en) begin
      if (hit_en)   en_q   <= wdata[SRC_W-1:0] & IMPL;
      if (hit_ctrl) mode_q <= wdata[MODE_W-1:0];
    end
  end

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      if (hit_stat)      rdata = DATA_W'(stat_q);
      else if (hit_en)   rdata = DATA_W'(en_q);
      else if (hit_ctrl) rdata = DATA_W'(mode_q);
    end
  end

endmodule

// File: rtl/isu_deliver.sv
module isu_deliver
  import isu_pkg::*;
#(
  parameter int SRC_W  = 16,
  parameter int MODE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SRC_W-1:0]  stat_q,
  input  logic [SRC_W-1:0]  en_q,
  input  logic [MODE_W-1:0] mode_q,
  output logic [SRC_W-1:0]  cause,
  output logic              wired_mode,
  output logic              irq_line,
  output logic              msg_req,
  output logic              err_halt
);

  localparam logic [SRC_W-1:0] ERRM = SRC_W'(src_mask(1'b1));

  logic [SRC_W-1:0] cause_prev;
  logic [SRC_W-1:0] fresh;

  assign cause      = stat_q & en_q;
  assign wired_mode = (mode_q == MODE_W'(MODE_WIRED));
  assign fresh      = SRC_W'(new_bits(32'(cause), 32'(cause_prev)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cause_prev <= '0;
    else        cause_prev <= cause;
  end

  assign irq_line = wired_mode && (|cause);
  assign msg_req  = !wired_mode && (|fresh);
  assign err_halt = |(cause & ERRM);

endmodule

// File: rtl/chan_irq_unit.sv
module chan_irq_unit
  import isu_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int SRC_W  = 16,
  parameter int MODE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SRC_W-1:0]  src_evt,
  input  logic              evt_pending,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq_line,
  output logic              msg_req,
  output logic              err_halt
);

  localparam logic [SRC_W-1:0] IMPL = SRC_W'(src_mask(1'b0));
  localparam logic [SRC_W-1:0] PEND = SRC_W'(1) << BIT_DONE;

  logic [SRC_W-1:0]  set_vec;
  logic [SRC_W-1:0]  clr_vec;
  logic [SRC_W-1:0]  stat_q;
  logic [SRC_W-1:0]  en_q;
  logic [SRC_W-1:0]  cause;
  logic [MODE_W-1:0] mode_q;
  logic              wired_mode;

  // pending records hold the completion source up like a repeating pulse
  assign set_vec = (src_evt | (evt_pending ? PEND : '0)) & IMPL;

  isu_status #(.SRC_W(SRC_W)) u_status (
    .clk(clk), .rst_n(rst_n),
    .set_vec(set_vec), .clr_vec(clr_vec), .stat_q(stat_q)
  );

  isu_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SRC_W(SRC_W), .MODE_W(MODE_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .stat_q(stat_q), .en_q(en_q), .mode_q(mode_q),
    .clr_vec(clr_vec), .rdata(rdata)
  );

  isu_deliver #(.SRC_W(SRC_W), .MODE_W(MODE_W)) u_deliver (
    .clk(clk), .rst_n(rst_n),
    .stat_q(stat_q), .en_q(en_q), .mode_q(mode_q),
    .cause(cause), .wired_mode(wired_mode),
    .irq_line(irq_line), .msg_req(msg_req), .err_halt(err_halt)
  );

endmodule

// File: rtl/chan_irq_unit_chk.sv
module chan_irq_unit_chk
  import isu_pkg::*;
#(
  parameter int SRC_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [SRC_W-1:0] set_vec,
  input logic [SRC_W-1:0] clr_vec,
  input logic [SRC_W-1:0] stat_q,
  input logic             evt_pending,
  input logic             wired_mode,
  input logic             irq_line,
  input logic             msg_req,
  input logic             err_halt
);

  localparam logic [SRC_W-1:0] IMPL = SRC_W'(src_mask(1'b0));
  localparam logic [SRC_W-1:0] ERRM = SRC_W'(src_mask(1'b1));

  a_r2_only_impl: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q & ~IMPL) == '0);

  a_r3_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ((set_vec & clr_vec) != '0) |=> (($past(set_vec & clr_vec) & ~stat_q) == '0));

  a_r3_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_vec & ~set_vec) != '0) |=> (($past(clr_vec & ~set_vec) & stat_q) == '0));

  a_r4_pending_holds: assert property (@(posedge clk) disable iff (!rst_n)
    evt_pending |=> stat_q[BIT_DONE]);

  a_r5_status_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec == '0 && clr_vec == '0) |=> $stable(stat_q));

  a_r6_irq_wired_only: assert property (@(posedge clk) disable iff (!rst_n)
    irq_line |-> wired_mode);

  a_r7_msg_not_wired: assert property (@(posedge clk) disable iff (!rst_n)
    msg_req |-> !wired_mode);

  a_r8_err_has_source: assert property (@(posedge clk) disable iff (!rst_n)
    err_halt |-> ((stat_q & ERRM) != '0));

endmodule

bind chan_irq_unit chan_irq_unit_chk #(.SRC_W(SRC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_vec(clr_vec),
  .stat_q(stat_q), .evt_pending(evt_pending), .wired_mode(wired_mode),
  .irq_line(irq_line), .msg_req(msg_req), .err_halt(err_halt)
);

// File: tb/test_chan_irq_unit.sv
module test_chan_irq_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] src_evt = '0;
  logic        evt_pending = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq_line, msg_req, err_halt;

  int n_cmp = 0;
  int n_bad = 0;

  localparam logic [11:0] A_CTRL = 12'h004, A_STAT = 12'h100,
                          A_CLR = 12'h108, A_EN = 12'h110;
  localparam logic [31:0] ALL = 32'h0000_4E03;

  always #10 clk = ~clk;

  chan_irq_unit i_chan_irq_unit (
    .clk(clk), .rst_n(rst_n), .src_evt(src_evt), .evt_pending(evt_pending),
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .irq_line(irq_line), .msg_req(msg_req), .err_halt(err_halt)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    #1 d = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic pulse(input logic [15:0] v);
    @(negedge clk);
    src_evt = v;
    @(negedge clk);
    src_evt = '0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R9 irq", {31'b0, irq_line}, 0);
    chk("R9 msg", {31'b0, msg_req}, 0);
    chk("R9 err", {31'b0, err_halt}, 0);
    rd(A_STAT, d); chk("R9 status", d, 0);
    rd(A_EN, d);   chk("R9 enable", d, 0);
    rd(A_CTRL, d); chk("R9 ctrl", d, 1);
  endtask

  task automatic t_map();
    logic [31:0] d;
    wr(A_EN, 32'hFFFF_FFFF);
    rd(A_EN, d); chk("R2 enable mask", d, ALL);
    pulse(16'hFFFF);
    rd(A_STAT, d); chk("R2 status mask", d, ALL);
    rd(A_CLR, d);  chk("R1 clear reads 0", d, 0);
    rd(12'h200, d); chk("R1 other offset", d, 0);
    wr(A_CTRL, 32'hFFFF_FFF5);
    rd(A_CTRL, d); chk("R1 ctrl nibble", d, 32'h5);
    wr(A_CTRL, 32'h1);
  endtask

  task automatic t_clear();
    logic [31:0] d;
    wr(A_CLR, 32'h0000_0002);
    rd(A_STAT, d); chk("R3 partial clear", d, ALL & ~32'h2);
    wr(A_CLR, 32'h0);
    rd(A_STAT, d); chk("R3 zero write", d, ALL & ~32'h2);
    wr(A_CLR, ALL);
    rd(A_STAT, d); chk("R3 full clear", d, 0);
    @(negedge clk);
    wr_en = 1'b1; addr = A_CLR; wdata = 32'h200; src_evt = 16'h0200;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0; src_evt = '0;
    rd(A_STAT, d); chk("R3 set wins over clear", d, 32'h200);
    wr(A_CLR, ALL);
  endtask

  task automatic t_pending();
    logic [31:0] d;
    @(negedge clk); evt_pending = 1'b1;
    wr(A_CLR, 32'h1);
    rd(A_STAT, d); chk("R4 clear ignored while pending", d, 32'h1);
    @(negedge clk); evt_pending = 1'b0;
    wr(A_CLR, 32'h1);
    rd(A_STAT, d); chk("R4 clear after drain", d, 0);
  endtask

  task automatic t_disabled();
    logic [31:0] d;
    wr(A_EN, 32'h0);
    pulse(16'h0400);
    rd(A_STAT, d); chk("R5 recorded when disabled", d, 32'h400);
    chk("R5 no irq when disabled", {31'b0, irq_line}, 0);
    chk("R8 no err when disabled", {31'b0, err_halt}, 0);
    wr(A_CLR, ALL);
  endtask

  task automatic t_wired();
    wr(A_EN, 32'h1);
    pulse(16'h0001);
    chk("R6 irq in wired mode", {31'b0, irq_line}, 1);
    chk("R8 completion not error", {31'b0, err_halt}, 0);
    chk("R7 no msg in wired mode", {31'b0, msg_req}, 0);
    wr(A_CTRL, 32'h0);
    chk("R6 irq off in message mode", {31'b0, irq_line}, 0);
    wr(A_CLR, ALL);
  endtask

  task automatic t_message();
    wr(A_EN, ALL);
    @(negedge clk);
    chk("R7 idle", {31'b0, msg_req}, 0);
    pulse(16'h0800);
    chk("R7 pulse on new cause", {31'b0, msg_req}, 1);
    chk("R8 error raises halt", {31'b0, err_halt}, 1);
    @(negedge clk);
    chk("R7 pulse one cycle", {31'b0, msg_req}, 0);
    pulse(16'h0800);
    chk("R7 no pulse for set bit", {31'b0, msg_req}, 0);
    pulse(16'h0001);
    chk("R7 pulse for second bit", {31'b0, msg_req}, 1);
    wr(A_CLR, ALL);
    chk("R8 halt drops after clear", {31'b0, err_halt}, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_map();
    t_clear();
    t_pending();
    t_disabled();
    t_wired();
    t_message();
    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule